// File: doc/BRIEF.md
# Skip-Symbol Elastic Clock-Compensation FIFO

This block is a two-clock elastic buffer for a serial receiver. Aligned 10-bit 8B/10B code groups enter on the recovered clock and leave on the local reference clock. The two clocks differ by a small frequency offset. The buffer keeps its fill level near the middle so that this offset never causes an overflow or an underflow. When the write side runs ahead, it drops skip code groups before they are stored. When the read side runs ahead, it sends the last skip code group a second time instead of advancing.

Nothing is stored until the upstream aligner reports lock. The read side starts to read only after a few words have built up. It then reads one word per read clock. The buffer holds 20 words. Each side computes its fill level from its own pointer and the other side's pointer. Each pointer crosses between the clock domains as a Gray code through two flops. A skip code group is the 10-bit pattern `SKIP_CODE` (default 10'b0011110100) or its bitwise complement. Four flags report an insertion, a deletion, a full buffer and an empty buffer.

Top module: `skip_elastic_fifo`

## Requirements
- R1: While `wr_rst` and `rd_rst` are high and in the cycle after they are released, `rd_sym` is 10'h000, `skip_ins`, `skip_del` and `buf_full` are 0, and `buf_empty` is 1.
- R2: While `lock_ok` is 0, no word is stored and none is deleted, so `buf_empty` stays 1 and `rd_sym` does not change.
- R3: If the buffer never fills, every non-skip word written while `lock_ok` is 1 appears on `rd_sym` once, in the order it was written.
- R4: A word is deleted only if it equals `SKIP_CODE` or ~`SKIP_CODE` and the write-side fill level is above `HI_MARK` (13). `skip_del` is high for the one write cycle that follows the write edge that sampled the deleted word.
- R5: There is at most one adjustment per skip occurrence. `skip_del` is never high on two write cycles in a row, and `skip_ins` is never high on two read cycles in a row.
- R6: If the read-side fill level is below `LO_MARK` (7) and the word on `rd_sym` is a skip code group, the next read edge outputs that same word again and does not advance. `skip_ins` is high in the cycle in which the word is repeated.
- R7: With no data to read, `buf_empty` is 1 and `rd_sym` keeps the last word read.
- R8: When the write-side fill level reaches 20, `buf_full` is 1 and incoming words are dropped. The words already stored still leave in order, uncorrupted, and `buf_full` clears once the buffer has drained.
- R9: With a write clock 5 % faster or slower than the read clock, and two skip code groups in every five words, the buffer does not fill and does not lose any non-skip word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered (write-side) clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| lock_ok | input | 1 | Word alignment is locked; words are written only while this is high |
| wr_sym | input | 10 | Incoming aligned 8B/10B code group |
| rd_clk | input | 1 | Local reference (read-side) clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_sym | output | 10 | Outgoing code group, registered |
| skip_ins | output | 1 | One read-cycle pulse: a skip code group is being repeated |
| skip_del | output | 1 | One write-cycle pulse: a skip code group was dropped |
| buf_full | output | 1 | Write-side fill level has reached 20 |
| buf_empty | output | 1 | Read-side fill level is zero |

## Verification
Each result is due at a known edge:
- `skip_del` is due one write edge after the word that caused it. The bench checks it on the next falling write edge, against the word it drove before that edge.
- `skip_ins` and its repeated word are due on the same read edge. The read monitor compares `rd_sym` with the value it recorded on the previous falling read edge.
- `buf_full` and `buf_empty` depend on pointers that take two or three edges of the other clock to arrive. The bench therefore checks these flags only after waiting dozens of cycles.
- Word order is checked at every falling read edge: each new non-skip word must match the head of the bench's own queue of written words.

// File: rtl/efifo_pkg.sv
package efifo_pkg;

    localparam int DEPTH = 20;
    localparam int SYMW  = 10;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(2 * DEPTH);
    localparam int GW    = AW + 1;
    localparam int OW    = $clog2(DEPTH + 1);
    localparam int GOFF  = (1 << AW) - DEPTH;

    typedef logic [SYMW-1:0] sym_t;
    typedef logic [AW-1:0]   addr_t;
    typedef logic [CW-1:0]   cnt_t;
    typedef logic [GW-1:0]   gray_t;
    typedef logic [OW-1:0]   occ_t;

    typedef struct packed {
        logic keep;
        logic drop_skip;
    } wr_act_t;

    typedef struct packed {
        logic advance;
        logic repeat_skip;
    } rd_act_t;

    // Counter runs 0 .. 2*DEPTH-1; shifted into the middle of a Gray cycle so wrap flips one bit
    function automatic gray_t cnt2gray(cnt_t c);
        gray_t b;
        b = gray_t'(int'(c) + GOFF);
        return b ^ (b >> 1);
    endfunction

    function automatic cnt_t gray2cnt(gray_t g);
        gray_t b;
        b[GW-1] = g[GW-1];
        for (int i = GW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return cnt_t'(int'(b) - GOFF);
    endfunction

    function automatic cnt_t cnt_inc(cnt_t c);
        return (int'(c) == 2 * DEPTH - 1) ? '0 : c + cnt_t'(1);
    endfunction

    function automatic addr_t cnt2addr(cnt_t c);
        return (int'(c) >= DEPTH) ? addr_t'(int'(c) - DEPTH) : addr_t'(c);
    endfunction

    function automatic occ_t occ_of(cnt_t w, cnt_t r);
        int d;
        d = int'(w) - int'(r);
        if (d < 0) d = d + 2 * DEPTH;
        return occ_t'(d);
    endfunction

    function automatic logic is_skip(sym_t s, sym_t code);
        return (s == code) || (s == ~code);
    endfunction

endpackage

// File: rtl/efifo_sync.sv
module efifo_sync
    import efifo_pkg::*;
#(
    parameter gray_t RST_VAL = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  gray_t d,
    output gray_t q
);

    gray_t meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/efifo_store.sv
module efifo_store
    import efifo_pkg::*;
(
    input  logic  wclk,
    input  logic  we,
    input  addr_t waddr,
    input  sym_t  wdata,
    input  addr_t raddr,
    output sym_t  rdata
);

    sym_t mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/efifo_wr.sv
module efifo_wr
    import efifo_pkg::*;
#(
    parameter int   HI_MARK   = 13,
    parameter sym_t SKIP_CODE = 10'b0011110100
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  lock,
    input  sym_t  din,
    input  gray_t rgray_s,
    output logic  we,
    output addr_t waddr,
    output sym_t  wdata,
    output gray_t wgray,
    output logic  del,
    output logic  full
);

    localparam occ_t HI   = occ_t'(HI_MARK);
    localparam occ_t FULL = occ_t'(DEPTH);

    cnt_t    wcnt;
    occ_t    occ_w;
    logic    din_skip;
    wr_act_t act;

    always_comb begin
        occ_w         = occ_of(wcnt, gray2cnt(rgray_s));
        full          = (occ_w >= FULL);
        din_skip      = is_skip(din, SKIP_CODE);
        act.drop_skip = lock && din_skip && (occ_w > HI) && !del;
        act.keep      = lock && !act.drop_skip && !full;
    end

    assign we    = act.keep;
    assign waddr = cnt2addr(wcnt);
    assign wdata = din;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt  <= '0;
            wgray <= cnt2gray('0);
            del   <= 1'b0;
        end else begin
            del <= act.drop_skip;
            if (act.keep) begin
                wcnt  <= cnt_inc(wcnt);
                wgray <= cnt2gray(cnt_inc(wcnt));
            end
        end
    end

    AST_LOCK_GATE: assert property (@(posedge clk) disable iff (rst)
        !lock |=> ($stable(wcnt) && !del)); // R2
    AST_DEL_ONLY_SKIP: assert property (@(posedge clk) disable iff (rst)
        $rose(del) |-> $past(din_skip)); // R4
    AST_DEL_SPACED: assert property (@(posedge clk) disable iff (rst)
        del |=> !del); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ_w <= FULL); // R8

endmodule

// File: rtl/efifo_rd.sv
module efifo_rd
    import efifo_pkg::*;
#(
    parameter int   LO_MARK    = 7,
    parameter int   START_MARK = 8,
    parameter sym_t SKIP_CODE  = 10'b0011110100
) (
    input  logic  clk,
    input  logic  rst,
    input  gray_t wgray_s,
    input  sym_t  mem_q,
    output addr_t raddr,
    output gray_t rgray,
    output sym_t  dout,
    output logic  ins,
    output logic  empty
);

    localparam occ_t LO    = occ_t'(LO_MARK);
    localparam occ_t START = occ_t'(START_MARK);

    cnt_t    rcnt;
    occ_t    occ_r;
    logic    primed;
    rd_act_t act;

    always_comb begin
        occ_r           = occ_of(gray2cnt(wgray_s), rcnt);
        empty           = (occ_r == '0);
        act.repeat_skip = primed && (occ_r < LO) && is_skip(dout, SKIP_CODE) && !ins;
        act.advance     = primed && !empty && !act.repeat_skip;
    end

    assign raddr = cnt2addr(rcnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            rcnt   <= '0;
            rgray  <= cnt2gray('0);
            dout   <= '0;
            ins    <= 1'b0;
            primed <= 1'b0;
        end else begin
            if (occ_r >= START) primed <= 1'b1;
            ins <= act.repeat_skip;
            if (act.advance) begin
                dout  <= mem_q;
                rcnt  <= cnt_inc(rcnt);
                rgray <= cnt2gray(cnt_inc(rcnt));
            end
        end
    end

    AST_INS_REPEATS: assert property (@(posedge clk) disable iff (rst)
        ins |-> $stable(dout)); // R6
    AST_INS_AFTER_SKIP: assert property (@(posedge clk) disable iff (rst)
        ins |-> is_skip(dout, SKIP_CODE)); // R6
    AST_INS_SPACED: assert property (@(posedge clk) disable iff (rst)
        ins |=> !ins); // R5
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        empty |=> $stable(dout)); // R7

endmodule

// File: rtl/skip_elastic_fifo.sv
module skip_elastic_fifo
    import efifo_pkg::*;
#(
    parameter int          HI_MARK    = 13,
    parameter int          LO_MARK    = 7,
    parameter int          START_MARK = 8,
    parameter logic [9:0]  SKIP_CODE  = 10'b0011110100
) (
    input  logic       wr_clk,
    input  logic       wr_rst,
    input  logic       lock_ok,
    input  logic [9:0] wr_sym,
    input  logic       rd_clk,
    input  logic       rd_rst,
    output logic [9:0] rd_sym,
    output logic       skip_ins,
    output logic       skip_del,
    output logic       buf_full,
    output logic       buf_empty
);

    localparam gray_t GRAY0 = cnt2gray('0);

    logic  we;
    addr_t waddr;
    addr_t raddr;
    sym_t  wdata;
    sym_t  mem_q;
    gray_t wgray;
    gray_t rgray;
    gray_t wgray_s;
    gray_t rgray_s;

    efifo_wr #(.HI_MARK(HI_MARK), .SKIP_CODE(SKIP_CODE)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .lock(lock_ok), .din(wr_sym),
        .rgray_s(rgray_s), .we(we), .waddr(waddr), .wdata(wdata),
        .wgray(wgray), .del(skip_del), .full(buf_full)
    );

    efifo_store u_mem (
        .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(mem_q)
    );

    efifo_sync #(.RST_VAL(GRAY0)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s)
    );

    efifo_sync #(.RST_VAL(GRAY0)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_s)
    );

    efifo_rd #(.LO_MARK(LO_MARK), .START_MARK(START_MARK), .SKIP_CODE(SKIP_CODE)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .wgray_s(wgray_s), .mem_q(mem_q),
        .raddr(raddr), .rgray(rgray), .dout(rd_sym), .ins(skip_ins),
        .empty(buf_empty)
    );

endmodule

// File: tb/sim_skip_elastic_fifo.sv
`timescale 1ns/1ps
module sim_skip_elastic_fifo;

    localparam logic [9:0] SKP = 10'b0011110100;

    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       wr_rst = 1'b1;
    logic       rd_rst = 1'b1;
    logic       lock_ok = 1'b0;
    logic [9:0] wr_sym = '0;
    logic [9:0] rd_sym;
    logic       skip_ins, skip_del, buf_full, buf_empty;

    real wr_half = 10.0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [9:0] exp_q[$];
    logic [9:0] data_ctr;
    logic [9:0] last_sym, prev_out, last_data;
    bit last_lock, prev_del, prev_ins, full_seen, mon_on, lossy;
    int del_total, del_bad, ins_total, ins_bad, ord_bad;

    skip_elastic_fifo u0 (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .lock_ok(lock_ok), .wr_sym(wr_sym),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_sym(rd_sym),
        .skip_ins(skip_ins), .skip_del(skip_del),
        .buf_full(buf_full), .buf_empty(buf_empty)
    );

    initial forever #10 rd_clk = ~rd_clk;
    initial begin
        #3;
        forever #(wr_half) wr_clk = ~wr_clk;
    end

    function automatic bit tb_skip(logic [9:0] s);
        return (s == SKP) || (s == ~SKP);
    endfunction

    function automatic logic [9:0] next_data(logic [9:0] d);
        logic [9:0] n;
        n = d + 10'd1;
        while (n == 10'd0 || tb_skip(n)) n = n + 10'd1;
        return n;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Read-side monitor: insertion legality and word order
    always @(negedge rd_clk) begin
        if (!rd_rst && mon_on) begin
            if (skip_ins) begin
                ins_total++;
                if (rd_sym != prev_out || !tb_skip(prev_out) || prev_ins) ins_bad++;
            end
            if (rd_sym != prev_out && !tb_skip(rd_sym)) begin
                if (lossy) begin
                    while (exp_q.size() > 0 && exp_q[0] != rd_sym) void'(exp_q.pop_front());
                end
                if (exp_q.size() == 0 || exp_q[0] != rd_sym) ord_bad++;
                else void'(exp_q.pop_front());
            end
            prev_out = rd_sym;
            prev_ins = skip_ins;
        end
    end

    task automatic do_reset();
        mon_on  = 0;
        lock_ok = 1'b0;
        wr_sym  = '0;
        wr_rst  = 1'b1;
        rd_rst  = 1'b1;
        repeat (5) @(posedge rd_clk);
        exp_q.delete();
        data_ctr = '0; last_sym = '0; prev_out = '0; last_data = '0;
        last_lock = 0; prev_del = 0; prev_ins = 0; full_seen = 0; lossy = 0;
        del_total = 0; del_bad = 0; ins_total = 0; ins_bad = 0; ord_bad = 0;
        @(negedge wr_clk) wr_rst = 1'b0;
        @(negedge rd_clk) rd_rst = 1'b0;
        mon_on = 1;
    endtask

    // mode 0: three data words then two skips (alternating disparity); mode 1: data only
    task automatic drive_stream(int n, int mode, bit lk);
        for (int i = 0; i < n; i++) begin
            logic [9:0] s;
            @(negedge wr_clk);
            if (skip_del) begin
                del_total++;
                if (!tb_skip(last_sym) || !last_lock || prev_del) del_bad++;
            end
            prev_del = skip_del;
            if (buf_full) full_seen = 1;
            if (mode == 0 && (i % 5) >= 3) s = ((i % 10) >= 5) ? ~SKP : SKP;
            else begin
                data_ctr = next_data(data_ctr);
                s = data_ctr;
            end
            lock_ok = lk;
            wr_sym  = s;
            if (lk && !tb_skip(s)) begin
                exp_q.push_back(s);
                last_data = s;
            end
            last_sym  = s;
            last_lock = lk;
        end
    endtask

    task automatic t_reset();
        wr_half = 10.0;
        do_reset();
        @(negedge rd_clk);
        check(rd_sym == 10'h000, "R1 rd_sym", int'(rd_sym), 0);
        check(skip_ins == 1'b0, "R1 skip_ins", int'(skip_ins), 0);
        check(skip_del == 1'b0, "R1 skip_del", int'(skip_del), 0);
        check(buf_full == 1'b0, "R1 buf_full", int'(buf_full), 0);
        check(buf_empty == 1'b1, "R1 buf_empty", int'(buf_empty), 1);
    endtask

    task automatic t_nolock();
        do_reset();
        drive_stream(80, 0, 1'b0);
        @(negedge rd_clk);
        check(buf_empty == 1'b1, "R2 empty while unlocked", int'(buf_empty), 1);
        check(rd_sym == 10'h000, "R2 output unchanged", int'(rd_sym), 0);
        check(del_total == 0, "R2 no deletion", del_total, 0);
    endtask

    task automatic t_nominal();
        wr_half = 10.0;
        do_reset();
        drive_stream(300, 0, 1'b1);
        drive_stream(80, 0, 1'b0);
        check(ord_bad == 0, "R3 order", ord_bad, 0);
        check(exp_q.size() == 0, "R3 all words out", exp_q.size(), 0);
        check(full_seen == 0, "R3 never full", int'(full_seen), 0);
    endtask

    task automatic t_fast();
        wr_half = 9.5;
        do_reset();
        drive_stream(600, 0, 1'b1);
        drive_stream(80, 0, 1'b0);
        check(del_total > 0, "R4 deletions occur", del_total, 1);
        check(del_bad == 0, "R4 R5 deletion legality", del_bad, 0);
        check(ord_bad == 0 && exp_q.size() == 0, "R9 fast write no loss", ord_bad + exp_q.size(), 0);
        check(full_seen == 0, "R9 fast write never full", int'(full_seen), 0);
    endtask

    task automatic t_slow();
        wr_half = 10.5;
        do_reset();
        drive_stream(600, 0, 1'b1);
        drive_stream(80, 0, 1'b0);
        check(ins_total > 0, "R6 insertions occur", ins_total, 1);
        check(ins_bad == 0, "R6 R5 insertion legality", ins_bad, 0);
        check(ord_bad == 0 && exp_q.size() == 0, "R9 slow write no loss", ord_bad + exp_q.size(), 0);
    endtask

    task automatic t_empty();
        logic [9:0] held;
        wr_half = 10.0;
        do_reset();
        drive_stream(40, 1, 1'b1);
        drive_stream(60, 1, 1'b0);
        @(negedge rd_clk);
        check(buf_empty == 1'b1, "R7 empty after drain", int'(buf_empty), 1);
        check(rd_sym == last_data, "R7 last word held", int'(rd_sym), int'(last_data));
        held = rd_sym;
        repeat (15) @(negedge rd_clk);
        check(rd_sym == held && ins_total == 0, "R7 output stable while empty", int'(rd_sym), int'(held));
    endtask

    task automatic t_full();
        wr_half = 8.0;
        do_reset();
        lossy = 1;
        drive_stream(200, 1, 1'b1);
        check(full_seen == 1, "R8 full seen", int'(full_seen), 1);
        drive_stream(100, 1, 1'b0);
        check(ord_bad == 0, "R8 stored words intact and ordered", ord_bad, 0);
        check(buf_full == 1'b0, "R8 full clears after drain", int'(buf_full), 0);
        check(del_total == 0, "R4 no deletion without skips", del_total, 0);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_nolock();
        t_nominal();
        t_fast();
        t_slow();
        t_empty();
        t_full();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule